// File: doc/BRIEF.md
# I2C Target Front End for a 16-bit Register Bank

This block lets an I2C controller read and update a bank of 16-bit registers. The registers are selected by an 8-bit command byte. The block follows the bus through two synchronizing flops and finds start, repeated-start and stop conditions. It matches the first byte after a start against its own address and against a shared broadcast address. It acknowledges accepted bytes by pulling SDA low through an open-drain enable. The register bank sits outside the block and is reached through a plain parallel port: pointer, write data, a one-cycle write strobe, and combinational read data. A small demonstration bank, `i2cr_demo_regs`, ships alongside the block.

**Write update.** The controller sends:
- the address with R/W = 0,
- the command byte, which becomes the pointer,
- a high data byte,
- a low data byte.

The register is written once, after the low byte.

**Combined read.** The controller sends the address (R/W = 0) and the command byte. It then issues a repeated start and sends the address with R/W = 1. The target returns the pointed register high byte first.

**Controller states.** `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address. `ST_ADDR_ACK` drives the acknowledge and then goes to `ST_CMD` for a write or `ST_RD` for a read.
- Write path: `ST_CMD` → `ST_CMD_ACK` → `ST_WHI` → `ST_WHI_ACK` → `ST_WLO` → `ST_WLO_ACK` → `ST_IGNORE`.
- Read path: `ST_RD` shifts a byte out. `ST_RD_ACK` samples the controller's acknowledge. It returns to `ST_RD` for the low byte only after an acknowledged high byte; otherwise it goes to `ST_IGNORE`.
- `ST_IGNORE` keeps SDA released.
- From every state, a start leads to `ST_ADDR` and a stop leads to `ST_IDLE`.

Top module: `i2cr_target`

## Requirements
- R1: After reset, the target leaves SDA released, the write strobe low, and the pointer at 00h.
- R2: Bus conditions and aborts.
  - A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. Both are seen through two-flop synchronizers.
  - A stop at any point returns the target to idle and writes no register, even after the command byte or the high data byte.
- R3: Own-address matching.
  - An address byte whose upper seven bits equal the device address (default 48h) is acknowledged for either R/W value.
  - Any other address, apart from the R4 case, is not acknowledged, and SDA stays released until the next start or stop.
- R4: Broadcast address.
  - The broadcast address (default 47h) is acknowledged with R/W = 0, and the write that follows takes effect.
  - With R/W = 1 it gets no acknowledge and SDA is not driven.
- R5: The byte after an acknowledged write address is acknowledged and appears on the pointer output.
- R6: Write updates.
  - The high and low data bytes are each acknowledged.
  - One single-cycle write strobe carries {high, low} after the low byte.
  - A fifth byte is not acknowledged.
- R7: After a repeated start and the address with R/W = 1, the target shifts out the pointed register high byte and then the low byte, each MSB first.
- R8: Ending a read.
  - If the controller does not acknowledge the high byte, no low byte follows.
  - After the low byte, SDA is released whatever the controller's acknowledge.
- R9: Demonstration bank contents.
  - Pointer 00h always reads 0000h and ignores writes.
  - Pointer 1Fh resets to 0FFFh; pointer 20h resets to 0000h; both are writable.
  - Every other pointer reads 0000h.
- R10: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Register pointer from the command byte |
| reg_wdata | output | 16 | Data for a register write, high byte first |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Contents of the register at `reg_addr` |

## Verification
The bench builds the target with the default device address 48h, broadcast address 47h and two synchronizer stages, and attaches the demonstration bank. It sweeps all 256 address-byte values, so every address and R/W combination meets the acknowledge decision, including the broadcast read refusal. It also reads every pointer from 00h to 2Fh, which covers both implemented registers, the no-operation register and many unimplemented pointers. Short SCL phases of five clocks keep these sweeps, the aborted transfers and the ended reads within the run length.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WHI,
        ST_WHI_ACK,
        ST_WLO,
        ST_WLO_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } i2cr_state_e;

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] scl_sr;
    logic [STAGES:0] sda_sr;
    logic            scl_p;
    logic            sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[STAGES-1:0], scl_i};
            sda_sr <= {sda_sr[STAGES-1:0], sda_i};
        end
    end

    assign scl_s     = scl_sr[STAGES-1];
    assign sda_s     = sda_sr[STAGES-1];
    assign scl_p     = scl_sr[STAGES];
    assign sda_p     = sda_sr[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h48,
    parameter logic [6:0] BCAST_ADDR = 7'h47,
    parameter int         BYTE_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_s,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    output logic                  sda_oe,
    output logic [BYTE_W-1:0]     reg_addr,
    output logic [2*BYTE_W-1:0]   reg_wdata,
    output logic                  reg_we,
    input  logic [2*BYTE_W-1:0]   reg_rdata
);
    localparam int REG_W = 2 * BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);

    i2cr_state_e        state_q, state_d;
    logic [BYTE_W-1:0]  sh_q;
    logic [BYTE_W-1:0]  ptr_q;
    logic [BYTE_W-1:0]  hi_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               rd_q;
    logic               lo_q;
    logic               mack_q;
    logic               we_q;
    logic               byte_done;
    logic               addr_ok;

    assign byte_done = (cnt_q == CNT_W'(BYTE_W));
    assign addr_ok   = (sh_q[BYTE_W-1:1] == DEV_ADDR) ||
                       ((sh_q[BYTE_W-1:1] == BCAST_ADDR) && !sh_q[0]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:     if (scl_fall && byte_done) state_d = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rd_q ? ST_RD : ST_CMD;
                ST_CMD:      if (scl_fall && byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_WHI;
                ST_WHI:      if (scl_fall && byte_done) state_d = ST_WHI_ACK;
                ST_WHI_ACK:  if (scl_fall) state_d = ST_WLO;
                ST_WLO:      if (scl_fall && byte_done) state_d = ST_WLO_ACK;
                ST_WLO_ACK:  if (scl_fall) state_d = ST_IGNORE;
                ST_RD:       if (scl_fall && cnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = (mack_q && !lo_q) ? ST_RD : ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte shifting, pointer and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            ptr_q  <= '0;
            hi_q   <= '0;
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            lo_q   <= 1'b0;
            mack_q <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (stop_det || start_det) begin
                cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WHI, ST_WLO: begin
                        if (scl_rise && !byte_done) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) rd_q  <= sh_q[0];
                            if (state_q == ST_CMD)  ptr_q <= sh_q;
                            if (state_q == ST_WHI)  hi_q  <= sh_q;
                            if (state_q == ST_WLO)  we_q  <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && rd_q) begin
                            sh_q  <= reg_rdata[REG_W-1:BYTE_W];
                            lo_q  <= 1'b0;
                            cnt_q <= '0;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                            cnt_q <= (cnt_q == CNT_W'(BYTE_W - 1)) ? '0 : cnt_q + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall && mack_q && !lo_q) begin
                            sh_q  <= reg_rdata[BYTE_W-1:0];
                            lo_q  <= 1'b1;
                            cnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WHI_ACK, ST_WLO_ACK: sda_oe = 1'b1;
            ST_RD:   sda_oe = ~sh_q[BYTE_W-1];
            default: sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = {hi_q, sh_q};
    assign reg_we    = we_q;

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    we_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state_q == ST_WLO_ACK));

    // R4
    bcast_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR_ACK) && (sh_q[BYTE_W-1:1] == BCAST_ADDR) && (BCAST_ADDR != DEV_ADDR))
            |-> !sh_q[0]);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R7
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BYTE_W));

endmodule

// File: rtl/i2cr_demo_regs.sv
module i2cr_demo_regs #(
    parameter int                 PTR_W     = 8,
    parameter int                 REG_W     = 16,
    parameter logic [PTR_W-1:0]   CFG_ADDR  = 8'h1F,
    parameter logic [REG_W-1:0]   CFG_RST   = 16'h0FFF,
    parameter logic [PTR_W-1:0]   TRIG_ADDR = 8'h20,
    parameter logic [REG_W-1:0]   TRIG_RST  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             we,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] trig_q;

    // R9: only two registers hold state; pointer 00h and all others read zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            trig_q <= TRIG_RST;
        end else if (we) begin
            if (addr == CFG_ADDR)  cfg_q  <= wdata;
            if (addr == TRIG_ADDR) trig_q <= wdata;
        end
    end

    always_comb begin
        if (addr == CFG_ADDR)       rdata = cfg_q;
        else if (addr == TRIG_ADDR) rdata = trig_q;
        else                        rdata = '0;
    end

endmodule

// File: rtl/i2cr_target.sv
module i2cr_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter logic [6:0] BCAST_ADDR  = 7'h47,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [7:0]  reg_addr,
    output logic [15:0] reg_wdata,
    output logic        reg_we,
    input  logic [15:0] reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cr_engine #(
        .DEV_ADDR   (DEV_ADDR),
        .BCAST_ADDR (BCAST_ADDR),
        .BYTE_W     (8)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/i2cr_target_tb.sv
module i2cr_target_tb;
    localparam int         Q   = 5;
    localparam logic [6:0] DEV = 7'h48;
    localparam logic [6:0] BC  = 7'h47;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        reg_we;

    int n_cmp = 0;
    int n_bad = 0;
    int we_cnt = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic [15:0] m_cfg = 16'h0FFF;
    logic [15:0] m_trig = 16'h0000;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2cr_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    i2cr_demo_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (rst_n && reg_we) we_cnt++;
        if (rst_n && scl_m && (oe_prev !== sda_oe)) oe_viol++;
        oe_prev <= sda_oe;
    end

    function automatic logic [15:0] model(input logic [7:0] p);
        if (p == 8'h1F)      return m_cfg;
        else if (p == 8'h20) return m_trig;
        else                 return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq(); hq();
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq();
            scl_m = 1'b1; hq(); hq();
            scl_m = 1'b0; hq();
        end
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        ack = !sda_line; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic recv(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hq();
            scl_m = 1'b1; hq();
            b[i] = sda_line; hq();
            scl_m = 1'b0; hq();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0; hq();
        sda_m = 1'b1;
    endtask

    task automatic reg_read(input logic [7:0] p, output logic [15:0] v, output bit ok);
        bit a1, a2, a3;
        logic [7:0] hi, lo;
        i2c_start();
        send({DEV, 1'b0}, a1);
        send(p, a2);
        // R5: pointer visible after command byte
        check(reg_addr == p, "R5 pointer", reg_addr, p);
        i2c_start();
        send({DEV, 1'b1}, a3);
        recv(1'b1, hi);
        recv(1'b0, lo);
        i2c_stop();
        v = {hi, lo};
        ok = a1 & a2 & a3;
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] p,
                             input logic [15:0] v, output bit ok);
        bit a1, a2, a3, a4;
        i2c_start();
        send({a, 1'b0}, a1);
        send(p, a2);
        send(v[15:8], a3);
        send(v[7:0], a4);
        i2c_stop();
        ok = a1 & a2 & a3 & a4;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit ok, ack, exp_ack;
        logic [15:0] v;
        logic [7:0] x;
        int w0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        check(reg_we == 1'b0, "R1 strobe low", reg_we, 0);
        check(reg_addr == 8'h00, "R1 pointer", reg_addr, 0);

        // R3 R4: sweep every address byte
        for (int b = 0; b < 256; b++) begin
            logic [7:0] ab;
            ab = 8'(b);
            exp_ack = (ab[7:1] == DEV) || ((ab[7:1] == BC) && !ab[0]);
            i2c_start();
            send(ab, ack);
            check(ack == exp_ack, (ab[7:1] == BC) ? "R4 broadcast ack" : "R3 address ack",
                  int'(ack), int'(exp_ack));
            if (ab == {DEV, 1'b1}) begin
                // R7: pointer still 00h, high byte zero; end with NACK
                recv(1'b0, x);
                check(x == 8'h00, "R7 read ptr 00h", x, 0);
            end else if (!exp_ack && (ab[3:0] == 4'h0 || ab[7:1] == BC)) begin
                // R3: target stays released after a non-matching address
                recv(1'b0, x);
                check(x == 8'hFF, "R3 released after nack", x, 8'hFF);
            end
            i2c_stop();
        end
        check(we_cnt == 0, "R2 no write in sweep", we_cnt, 0);

        // R9 R7: read every pointer 00h..2Fh from reset
        for (int p = 0; p < 48; p++) begin
            reg_read(8'(p), v, ok);
            check(ok, "R5 read acks", int'(ok), 1);
            check(v == model(8'(p)), "R9 reset contents", v, model(8'(p)));
        end

        // R6: write updates
        w0 = we_cnt;
        reg_write(DEV, 8'h1F, 16'hA5C3, ok); m_cfg = 16'hA5C3;
        check(ok, "R6 write acks", int'(ok), 1);
        check(we_cnt == w0 + 1, "R6 one strobe", we_cnt - w0, 1);
        reg_read(8'h1F, v, ok);
        check(v == 16'hA5C3, "R7 readback 1Fh", v, 16'hA5C3);
        reg_write(DEV, 8'h20, 16'h1234, ok); m_trig = 16'h1234;
        reg_read(8'h20, v, ok);
        check(v == 16'h1234, "R7 readback 20h", v, 16'h1234);

        // R9: no-op register and unimplemented pointer
        reg_write(DEV, 8'h00, 16'hFFFF, ok);
        check(ok, "R6 write acks 00h", int'(ok), 1);
        reg_read(8'h00, v, ok);
        check(v == 16'h0000, "R9 nop reads zero", v, 0);
        reg_write(DEV, 8'h2A, 16'h7777, ok);
        reg_read(8'h2A, v, ok);
        check(v == 16'h0000, "R9 unimplemented", v, 0);
        reg_read(8'h1F, v, ok);
        check(v == 16'hA5C3, "R9 cfg intact", v, 16'hA5C3);

        // R2: stop after high byte, and after command byte
        w0 = we_cnt;
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h20, ack); send(8'hEE, ack); i2c_stop();
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h20, ack); i2c_stop();
        check(we_cnt == w0, "R2 aborted no strobe", we_cnt - w0, 0);
        reg_read(8'h20, v, ok);
        check(v == 16'h1234, "R2 register unchanged", v, 16'h1234);

        // R6: fifth byte is refused
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h1F, ack);
        send(8'h11, ack); send(8'h22, ack);
        send(8'h33, ack);
        check(ack == 1'b0, "R6 extra byte nack", int'(ack), 0);
        i2c_stop();
        m_cfg = 16'h1122;
        reg_read(8'h1F, v, ok);
        check(v == 16'h1122, "R6 written value", v, 16'h1122);

        // R4: broadcast write takes effect
        reg_write(BC, 8'h20, 16'h5A5A, ok); m_trig = 16'h5A5A;
        check(ok, "R4 broadcast write acks", int'(ok), 1);
        reg_read(8'h20, v, ok);
        check(v == 16'h5A5A, "R4 broadcast write", v, 16'h5A5A);

        // R4: broadcast read in a combined transfer
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h1F, ack);
        i2c_start(); send({BC, 1'b1}, ack);
        check(ack == 1'b0, "R4 broadcast read nack", int'(ack), 0);
        recv(1'b0, x);
        check(x == 8'hFF, "R4 sda not driven", x, 8'hFF);
        i2c_stop();

        // R8: NACK on high byte ends read
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h1F, ack);
        i2c_start(); send({DEV, 1'b1}, ack);
        recv(1'b0, x);
        check(x == 8'h11, "R7 high byte", x, 8'h11);
        recv(1'b0, x);
        check(x == 8'hFF, "R8 no low byte after nack", x, 8'hFF);
        i2c_stop();

        // R8: ACK after low byte still ends read
        i2c_start(); send({DEV, 1'b0}, ack); send(8'h1F, ack);
        i2c_start(); send({DEV, 1'b1}, ack);
        recv(1'b1, x);
        recv(1'b1, x);
        check(x == 8'h22, "R7 low byte", x, 8'h22);
        recv(1'b0, x);
        check(x == 8'hFF, "R8 released after low", x, 8'hFF);
        i2c_stop();

        // R10: drive enable never moved with SCL high
        check(oe_viol == 0, "R10 oe only while scl low", oe_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule